// File: doc/BRIEF.md
# Hypervisor Maintenance Interrupt Controller

This block holds the hypervisor-side state of a virtualised interrupt interface for up to `NUM_CPU` processors. For every CPU it keeps a control word, a virtual machine control word and `NUM_LR` list registers. From these it derives three status views: which list entries have completed with a maintenance request, which entries are empty, and an eight-bit maintenance status word. It also drives one level-sensitive maintenance interrupt line per CPU.

Software reaches the registers over a simple single-cycle register bus. An offset below 0x200 selects the register copy of the requesting CPU (banked access). A nonzero value in the address bits above bit 8 names a CPU directly, so a hypervisor on one core can inspect or program another core's copy. Every request receives exactly one response in the following cycle, carrying read data or an error flag.

Register offsets within a 0x200 slice are as follows:
- 0x000: control
- 0x004: type
- 0x008: VM control
- 0x010: maintenance status
- 0x020: EOI status
- 0x030: empty status
- 0x0F0: active priority
- 0x100 + 4*i: list register i

Top module: `hv_maint_ctrl`

## Requirements
- R1: With address bits [ADDR_W-1:9] equal to zero, a request reaches the register copy of the CPU given on `req_cpu`.
- R2: With address bits [ADDR_W-1:9] nonzero, that value names the target CPU, and bits [8:0] give the register offset.
- R3: A target CPU number of `NUM_CPU` or above gets an error response with read data zero, and a write to it changes no state.
- R4: The type register at 0x004 reads 0x44000000 OR (NUM_LR-1). It is read-only.
- R5: The VM control register at 0x008 keeps only these fields:
  - priority mask [31:27]
  - binary point [23:21]
  - aliased binary point [20:18]
  - EOI mode [9]
  - common binary point [4]
  - FIQ enable [3]
  - ack control [2]
  - group 1 enable [1]
  - group 0 enable [0]

  All other bits read as zero, so writing all ones reads back 0xF8FC021F.
- R6: The control register at 0x000 keeps the following bits, and all other bits read as zero:
  - enable [0]
  - underflow enable [1]
  - entry-not-present enable [2]
  - no-pending enable [3]
  - group 0 enabled/disabled enables [4]/[5]
  - group 1 enabled/disabled enables [6]/[7]
  - EOI count [31:27]
- R7: List registers are stored whole. A list entry's state is bits [29:28], where 0 is invalid, 1 is pending, 2 is active and 3 is pending+active; bit 19 is its EOI-maintenance flag. EOI status (0x020) bit i is set when entry i is invalid and has its flag set. Empty status (0x030) bit i is set when entry i is invalid.
- R8: The maintenance status word (0x010) has these low bits:
  - bit 0: the EOI status is nonzero
  - bit 1: underflow enable is set and at most one entry is non-invalid
  - bit 2: entry-not-present enable is set and the EOI count is nonzero
  - bit 3: no-pending enable is set and no entry has state bit 28 set
- R9: The maintenance status word has these high bits:
  - bit 4: its enable is set and VM group 0 enable is 1
  - bit 5: its enable is set and VM group 0 enable is 0
  - bit 6: its enable is set and VM group 1 enable is 1
  - bit 7: its enable is set and VM group 1 enable is 0
- R10: `maint_irq[c]` is high exactly when CPU c's control enable bit is set and its status word is nonzero. It settles in the cycle after the write that changes either.
- R11: The active priority register (0x0F0) reads zero, and writes to it are accepted without error and discarded.
- R12: An offset that names no register, including a misaligned offset or a list index of `NUM_LR` or above, gets an error response with read data zero.
- R13: Each request is answered by `rsp_valid` exactly one cycle later, and no response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cpu | input | CPU_W | Number of the requesting CPU |
| req_addr | input | ADDR_W | Byte offset: CPU slice in [ADDR_W-1:9], register in [8:0] |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_err | output | 1 | Request addressed no legal register |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| maint_irq | output | NUM_CPU | Level maintenance interrupt per CPU |

## Verification
A bus response is due one cycle after its request: the register sits on the clock edge that accepts the request. The maintenance interrupt and status are combinational from the stored registers, so they are valid in the cycle after a write, in the same sample slot as that write's response. The driver pushes each expected response into a queue as it presents the request. The monitor pops and compares at the falling edge after the next rising edge. Interrupt lines are compared at that same falling edge, directly after the write that should move them.

// File: rtl/hv_mi_pkg.sv
package hv_mi_pkg;

  // Register offsets inside one 0x200 slice
  localparam logic [8:0] OFF_CTRL  = 9'h000;
  localparam logic [8:0] OFF_TYPE  = 9'h004;
  localparam logic [8:0] OFF_VMCTL = 9'h008;
  localparam logic [8:0] OFF_STAT  = 9'h010;
  localparam logic [8:0] OFF_EOIST = 9'h020;
  localparam logic [8:0] OFF_EMPTY = 9'h030;
  localparam logic [8:0] OFF_APRI  = 9'h0F0;
  localparam logic [8:0] OFF_LIST  = 9'h100;

  // Writable bits
  localparam logic [31:0] CTRL_MASK  = 32'hF800_00FF;
  localparam logic [31:0] VMCTL_MASK = 32'hF8FC_021F;

  // Control word fields
  localparam int CT_EN     = 0;
  localparam int CT_UNDER  = 1;
  localparam int CT_NOENT  = 2;
  localparam int CT_NOPEND = 3;
  localparam int CT_G0ON   = 4;
  localparam int CT_G0OFF  = 5;
  localparam int CT_G1ON   = 6;
  localparam int CT_G1OFF  = 7;
  localparam int CT_CNT_LO = 27;

  // VM control fields used by status
  localparam int VM_G0EN = 0;
  localparam int VM_G1EN = 1;

  // List entry fields
  localparam int LE_EOI    = 19;
  localparam int LE_ST_LO  = 28;
  localparam int LE_ST_HI  = 29;

  localparam logic [31:0] TYPE_BASE = 32'h4400_0000;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_TYPE,
    SEL_VMCTL,
    SEL_STAT,
    SEL_EOIST,
    SEL_EMPTY,
    SEL_APRI,
    SEL_LIST
  } reg_sel_e;

endpackage

// File: rtl/hv_mi_decode.sv
module hv_mi_decode
  import hv_mi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_LR  = 4,
  parameter int ADDR_W  = 13,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int LR_W   = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [CPU_W-1:0]  tgt_cpu,
  output reg_sel_e          sel,
  output logic [LR_W-1:0]   lr_idx,
  output logic              bad
);
  localparam int SLICE_W = ADDR_W - 9;

  logic [SLICE_W-1:0] slice;
  logic [SLICE_W-1:0] tgt_wide;
  logic [8:0]         off;
  logic [8:0]         lr_rel;
  logic               bad_cpu;

  assign slice    = req_addr[ADDR_W-1:9];
  assign off      = req_addr[8:0];
  assign tgt_wide = (slice != '0) ? slice : SLICE_W'(req_cpu);
  assign bad_cpu  = (32'(tgt_wide) >= NUM_CPU);
  assign tgt_cpu  = CPU_W'(tgt_wide);
  assign lr_rel   = off - OFF_LIST;
  assign lr_idx   = LR_W'(lr_rel >> 2);

  always_comb begin
    sel = SEL_NONE;
    unique case (off)
      OFF_CTRL:  sel = SEL_CTRL;
      OFF_TYPE:  sel = SEL_TYPE;
      OFF_VMCTL: sel = SEL_VMCTL;
      OFF_STAT:  sel = SEL_STAT;
      OFF_EOIST: sel = SEL_EOIST;
      OFF_EMPTY: sel = SEL_EMPTY;
      OFF_APRI:  sel = SEL_APRI;
      default: begin
        if (off >= OFF_LIST && 32'(lr_rel) < 4 * NUM_LR && off[1:0] == 2'b00)
          sel = SEL_LIST;
      end
    endcase
  end

  assign bad = bad_cpu || (sel == SEL_NONE);

endmodule

// File: rtl/hv_mi_bank.sv
module hv_mi_bank
  import hv_mi_pkg::*;
#(
  parameter int NUM_LR = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_ctrl,
  input  logic                    wr_vmctl,
  input  logic [NUM_LR-1:0]       wr_list,
  input  logic [31:0]             wdata,
  output logic [31:0]             ctrl_q,
  output logic [31:0]             vmctl_q,
  output logic [NUM_LR-1:0][31:0] list_q,
  output logic [NUM_LR-1:0]       eoi_status,
  output logic [NUM_LR-1:0]       empty_status,
  output logic [7:0]              stat_word,
  output logic                    irq
);

  function automatic logic entry_live(logic [31:0] e);
    return e[LE_ST_HI:LE_ST_LO] != 2'b00;
  endfunction

  function automatic logic entry_wants_eoi(logic [31:0] e);
    return !entry_live(e) && e[LE_EOI];
  endfunction

  function automatic int unsigned count_live(logic [NUM_LR-1:0] live);
    int unsigned n = 0;
    for (int i = 0; i < NUM_LR; i++) n += int'(live[i]);
    return n;
  endfunction

  function automatic logic [7:0] status_of(logic [31:0] c, logic [31:0] v,
                                           logic [NUM_LR-1:0] eoi,
                                           logic [NUM_LR-1:0] live,
                                           logic any_pend);
    logic [7:0] s;
    s[0] = |eoi;
    s[1] = c[CT_UNDER] && (count_live(live) <= 1);
    s[2] = c[CT_NOENT] && (c[31:CT_CNT_LO] != '0);
    s[3] = c[CT_NOPEND] && !any_pend;
    s[4] = c[CT_G0ON] && v[VM_G0EN];
    s[5] = c[CT_G0OFF] && !v[VM_G0EN];
    s[6] = c[CT_G1ON] && v[VM_G1EN];
    s[7] = c[CT_G1OFF] && !v[VM_G1EN];
    return s;
  endfunction

  logic [NUM_LR-1:0] live_vec;
  logic [NUM_LR-1:0] pend_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      vmctl_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= wdata & CTRL_MASK;
      if (wr_vmctl) vmctl_q <= wdata & VMCTL_MASK;
    end
  end

  for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)          list_q[i] <= '0;
      else if (wr_list[i]) list_q[i] <= wdata;
    end
    assign live_vec[i]     = entry_live(list_q[i]);
    assign pend_vec[i]     = list_q[i][LE_ST_LO];
    assign eoi_status[i]   = entry_wants_eoi(list_q[i]);
    assign empty_status[i] = !live_vec[i];
  end

  assign stat_word = status_of(ctrl_q, vmctl_q, eoi_status, live_vec, |pend_vec);
  assign irq       = ctrl_q[CT_EN] && (stat_word != 8'h00);

endmodule

// File: rtl/hv_maint_ctrl.sv
module hv_maint_ctrl
  import hv_mi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_LR  = 4,
  parameter int ADDR_W  = 13,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int LR_W   = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [CPU_W-1:0]   req_cpu,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [31:0]        rsp_rdata,
  output logic [NUM_CPU-1:0] maint_irq
);
  localparam logic [31:0] TYPE_VAL = TYPE_BASE | 32'(NUM_LR - 1);

  logic [CPU_W-1:0] tgt_cpu;
  reg_sel_e         sel;
  logic [LR_W-1:0]  lr_idx;
  logic             bad;
  logic             wr_ok;
  logic [31:0]      rd_mux;

  logic [31:0]             ctrl_a  [NUM_CPU];
  logic [31:0]             vmctl_a [NUM_CPU];
  logic [NUM_LR-1:0][31:0] list_a  [NUM_CPU];
  logic [NUM_LR-1:0]       eoi_a   [NUM_CPU];
  logic [NUM_LR-1:0]       empty_a [NUM_CPU];
  logic [7:0]              stat_a  [NUM_CPU];

  // Named events for the checker
  logic [NUM_CPU-1:0] hcr_en_vec;
  logic [NUM_CPU-1:0] stat_nz_vec;

  hv_mi_decode #(
    .NUM_CPU(NUM_CPU), .NUM_LR(NUM_LR), .ADDR_W(ADDR_W)
  ) u_dec (
    .req_cpu (req_cpu),
    .req_addr(req_addr),
    .tgt_cpu (tgt_cpu),
    .sel     (sel),
    .lr_idx  (lr_idx),
    .bad     (bad)
  );

  assign wr_ok = req_valid && req_write && !bad;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic              hit;
    logic [NUM_LR-1:0] wr_list;

    assign hit = wr_ok && (tgt_cpu == CPU_W'(c));
    for (genvar i = 0; i < NUM_LR; i++) begin : g_lw
      assign wr_list[i] = hit && (sel == SEL_LIST) && (lr_idx == LR_W'(i));
    end

    hv_mi_bank #(.NUM_LR(NUM_LR)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ctrl     (hit && sel == SEL_CTRL),
      .wr_vmctl    (hit && sel == SEL_VMCTL),
      .wr_list     (wr_list),
      .wdata       (req_wdata),
      .ctrl_q      (ctrl_a[c]),
      .vmctl_q     (vmctl_a[c]),
      .list_q      (list_a[c]),
      .eoi_status  (eoi_a[c]),
      .empty_status(empty_a[c]),
      .stat_word   (stat_a[c]),
      .irq         (maint_irq[c])
    );

    assign hcr_en_vec[c]  = ctrl_a[c][CT_EN];
    assign stat_nz_vec[c] = |stat_a[c];
  end

  always_comb begin
    rd_mux = '0;
    if (!bad) begin
      unique case (sel)
        SEL_CTRL:  rd_mux = ctrl_a[tgt_cpu];
        SEL_TYPE:  rd_mux = TYPE_VAL;
        SEL_VMCTL: rd_mux = vmctl_a[tgt_cpu];
        SEL_STAT:  rd_mux = 32'(stat_a[tgt_cpu]);
        SEL_EOIST: rd_mux = 32'(eoi_a[tgt_cpu]);
        SEL_EMPTY: rd_mux = 32'(empty_a[tgt_cpu]);
        SEL_LIST:  rd_mux = list_a[tgt_cpu][lr_idx];
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/hv_maint_ctrl_chk.sv
module hv_maint_ctrl_chk #(
  parameter int NUM_CPU = 8,
  parameter int NUM_LR  = 4,
  parameter int ADDR_W  = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [31:0]        rsp_rdata,
  input logic [NUM_CPU-1:0] maint_irq,
  input logic [NUM_CPU-1:0] hcr_en_vec,
  input logic [NUM_CPU-1:0] stat_nz_vec
);
  localparam logic [31:0] TYPE_EXP = 32'h4400_0000 | 32'(NUM_LR - 1);

  // R13
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R13
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == 32'h0);

  // R3
  slice_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && 32'(req_addr[ADDR_W-1:9]) >= NUM_CPU) |=> rsp_err);

  // R4
  type_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == ADDR_W'(12'h004))
      |=> (rsp_rdata == TYPE_EXP && !rsp_err));

  // R11
  apr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == ADDR_W'(12'h0F0))
      |=> (rsp_rdata == 32'h0 && !rsp_err));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
    // R10
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hcr_en_vec[c] |-> !maint_irq[c]);
    // R10
    irq_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_nz_vec[c] |-> !maint_irq[c]);
    // R10
    irq_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hcr_en_vec[c] && stat_nz_vec[c]) |-> maint_irq[c]);
  end

endmodule

bind hv_maint_ctrl hv_maint_ctrl_chk #(
  .NUM_CPU(NUM_CPU), .NUM_LR(NUM_LR), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_rdata  (rsp_rdata),
  .maint_irq  (maint_irq),
  .hcr_en_vec (hcr_en_vec),
  .stat_nz_vec(stat_nz_vec)
);

// File: tb/tb_hv_maint_ctrl.sv
module tb_hv_maint_ctrl;
  localparam int NC = 8;
  localparam int NL = 4;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [2:0]    req_cpu = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_err;
  logic [31:0]   rsp_rdata;
  logic [NC-1:0] maint_irq;

  always #4 clk = ~clk;

  hv_maint_ctrl #(.NUM_CPU(NC), .NUM_LR(NL), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .maint_irq(maint_irq)
  );

  int          n_run = 0;
  int          n_fail = 0;
  logic [31:0] q_data[$];
  logic        q_err[$];
  string       q_tag[$];

  task automatic note(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: one response per request, compared in order
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) begin
        n_run++;
        n_fail++;
        $display("FAIL R13 unexpected response: actual 1 expected 0");
      end else begin
        logic [31:0] d;
        logic        e;
        string       t;
        d = q_data.pop_front();
        e = q_err.pop_front();
        t = q_tag.pop_front();
        note(t, rsp_rdata, d);
        note({t, " err"}, {31'b0, rsp_err}, {31'b0, e});
      end
    end
  end

  task automatic access(input logic [2:0] cpu, input logic [AW-1:0] addr,
                        input logic we, input logic [31:0] wd,
                        input logic [31:0] exp_d, input logic exp_e, input string tag);
    q_data.push_back(exp_d);
    q_err.push_back(exp_e);
    q_tag.push_back(tag);
    req_cpu   = cpu;
    req_addr  = addr;
    req_write = we;
    req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic wr(input logic [2:0] cpu, input logic [AW-1:0] addr,
                    input logic [31:0] wd, input string tag);
    access(cpu, addr, 1'b1, wd, 32'h0, 1'b0, tag);
  endtask

  task automatic rd(input logic [2:0] cpu, input logic [AW-1:0] addr,
                    input logic [31:0] exp_d, input string tag);
    access(cpu, addr, 1'b0, 32'h0, exp_d, 1'b0, tag);
  endtask

  task automatic irq_is(input logic [NC-1:0] exp, input string tag);
    note(tag, 32'(maint_irq), 32'(exp));
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R1, R6, R7, R10)
    irq_is(8'h00, "R10 reset irq");
    rd(0, 13'h000, 32'h0, "R6 reset ctrl");
    rd(0, 13'h008, 32'h0, "R5 reset vmctl");
    rd(0, 13'h030, 32'h0000000F, "R7 reset empty");
    rd(0, 13'h020, 32'h0, "R7 reset eoi status");
    rd(0, 13'h010, 32'h0, "R8 reset status");
    rd(0, 13'h004, 32'h44000003, "R4 type");

    // R5 writable fields of VM control
    wr(0, 13'h008, 32'hFFFFFFFF, "R5 vmctl write");
    rd(0, 13'h008, 32'hF8FC021F, "R5 vmctl mask");
    wr(0, 13'h008, 32'h0, "R5 vmctl clear");

    // R6 writable bits of control; status with every enable on
    wr(7, 13'h000, 32'hFFFFFFFF, "R6 ctrl write");
    irq_is(8'h80, "R10 cpu7 irq raised");
    rd(7, 13'h000, 32'hF80000FF, "R6 ctrl mask");
    rd(7, 13'h010, 32'h000000AE, "R9 all enables status");
    wr(7, 13'h000, 32'h0, "R6 ctrl clear");
    irq_is(8'h00, "R10 cpu7 irq dropped");

    // R1 banked access, R8 no-pending and EOI bits, R7
    wr(1, 13'h000, 32'h00000009, "R1 cpu1 ctrl");
    irq_is(8'h02, "R8 no-pending irq");
    rd(1, 13'h010, 32'h00000008, "R8 no-pending status");
    wr(1, 13'h100, 32'h10000000, "R1 cpu1 entry0 pending");
    irq_is(8'h00, "R8 pending clears no-pending");
    rd(1, 13'h010, 32'h0, "R8 status after pending");
    rd(1, 13'h030, 32'h0000000E, "R7 empty with one pending");
    wr(1, 13'h100, 32'h00080000, "R7 entry0 invalid with eoi");
    irq_is(8'h02, "R8 eoi irq");
    rd(1, 13'h020, 32'h00000001, "R7 eoi status");
    rd(1, 13'h030, 32'h0000000F, "R7 empty all");
    rd(1, 13'h010, 32'h00000009, "R8 eoi plus no-pending");
    wr(1, 13'h000, 32'h00000008, "R10 cpu1 enable off");
    irq_is(8'h00, "R10 enable gates irq");
    rd(1, 13'h010, 32'h00000009, "R10 status kept while disabled");

    // R2 direct slice access, R8 underflow boundary
    wr(0, 13'h600, 32'h00000003, "R2 direct ctrl cpu3");
    irq_is(8'h08, "R2 cpu3 irq via slice");
    rd(3, 13'h010, 32'h00000002, "R8 underflow zero live");
    wr(3, 13'h100, 32'h10000000, "R8 cpu3 entry0 pending");
    wr(3, 13'h104, 32'h20000000, "R8 cpu3 entry1 active");
    irq_is(8'h00, "R8 two live no underflow");
    rd(3, 13'h010, 32'h0, "R8 status two live");
    wr(3, 13'h104, 32'h0, "R8 cpu3 entry1 invalid");
    irq_is(8'h08, "R8 one live underflow");
    rd(5, 13'h704, 32'h0, "R2 direct read entry1");
    rd(5, 13'h700, 32'h10000000, "R2 direct read entry0");
    rd(6, 13'h210, 32'h00000009, "R2 direct read cpu1 status");

    // R9 group status bits on cpu4
    wr(0, 13'h800, 32'h00000031, "R9 cpu4 g0 enables");
    rd(0, 13'h810, 32'h00000020, "R9 g0 disabled");
    wr(0, 13'h808, 32'h00000001, "R9 g0 on");
    rd(0, 13'h810, 32'h00000010, "R9 g0 enabled");
    wr(0, 13'h800, 32'h000000C1, "R9 cpu4 g1 enables");
    rd(4, 13'h010, 32'h00000080, "R9 g1 disabled");
    wr(4, 13'h008, 32'h00000002, "R9 g1 on");
    rd(4, 13'h010, 32'h00000040, "R9 g1 enabled");
    irq_is(8'h18, "R10 cpu3 and cpu4 irq");

    // R8 EOI count bit on cpu5
    wr(5, 13'h000, 32'h08000005, "R8 count one");
    rd(5, 13'h010, 32'h00000004, "R8 count status");
    irq_is(8'h38, "R10 cpu5 irq");
    wr(5, 13'h000, 32'h00000005, "R8 count zero");
    rd(5, 13'h010, 32'h0, "R8 count zero status");

    // R11 active priority
    wr(0, 13'h0F0, 32'hFFFFFFFF, "R11 apr write");
    rd(0, 13'h0F0, 32'h0, "R11 apr read");

    // R3 illegal CPU slices, R12 unmapped offsets
    access(0, 13'h1000, 1'b0, 32'h0, 32'h0, 1'b1, "R3 slice 8 read");
    access(0, 13'h1000, 1'b1, 32'h1, 32'h0, 1'b1, "R3 slice 8 write");
    access(2, 13'h1210, 1'b0, 32'h0, 32'h0, 1'b1, "R3 slice 9 read");
    access(0, 13'h000C, 1'b0, 32'h0, 32'h0, 1'b1, "R12 unmapped");
    access(0, 13'h0102, 1'b0, 32'h0, 32'h0, 1'b1, "R12 misaligned");
    access(0, 13'h0110, 1'b1, 32'h1, 32'h0, 1'b1, "R12 entry beyond count");
    irq_is(8'h18, "R3 illegal writes change nothing");
    rd(0, 13'h000, 32'h0, "R3 cpu0 ctrl unchanged");

    @(negedge clk);
    n_run++;
    if (q_data.size() != 0) begin
      n_fail++;
      $display("FAIL R13 missing responses: actual %0d expected 0", q_data.size());
    end
    finish_run();
  end

endmodule